// File: doc/BRIEF.md
# Sixteen-Operation 32-bit ALU

This block is a purely combinational arithmetic logic unit. It takes two operands and a 4-bit operation code and drives one result word in the same cycle. It has no clock, no reset, no internal state and no flag outputs. The operation set has sixteen entries: bitwise logic, wrapping add and subtract, low-word and high-word multiplies in signed and unsigned forms, unsigned quotient and remainder, three shifts, signed less-than, a population count taken over both operands together, and a test for whether one operand is the bit-mirror of the other.

A datapath places the block between its operand registers and its writeback. The surrounding logic turns instructions into the operation code. Every operation is computed in parallel by one of four sub-units, and the code only steers the final result multiplexer. No arithmetic result raises an overflow or error indication. Division by zero gives fixed values that stay within range.

Top module: `sixteen_op_alu`

## Requirements
- R1: Codes 0, 1 and 2 return A AND B, A OR B and A XOR B respectively.
- R2: Code 3 returns A+B and code 4 returns A-B, both taken modulo 2^32 with overflow discarded.
- R3: Code 5 returns bits 31:0 of the product A*B.
- R4: Code 6 returns bits 63:32 of the product of A and B, with both read as unsigned.
- R5: Code 7 returns bits 63:32 of the product of A and B, with both read as two's complement.
- R6: Code 8 returns the unsigned quotient A/B. When B is zero it returns 0xFFFFFFFF.
- R7: Code 9 returns the unsigned remainder A%B. When B is zero it returns A unchanged.
- R8: Codes 10 and 11 shift A right by B[4:0]. Code 10 fills with zeros and code 11 fills with A[31]. Bits B[31:5] have no effect.
- R9: Code 12 shifts A left by B[4:0] and fills with zeros. Bits B[31:5] have no effect.
- R10: Code 13 returns 1 when A is less than B as signed two's-complement values, otherwise 0.
- R11: Code 14 returns the number of 1 bits in A plus the number of 1 bits in B. The value lies in 0 to 64.
- R12: Code 15 returns 1 when A[i] equals B[31-i] for every i from 0 to 31, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; also the shift amount and the divisor |
| sel_i | input | 4 | Operation code, encoded as in R1 to R12 |
| result_o | output | 32 | Result of the selected operation |

## Verification
Some outcomes are hard to reach from the ports. Code 15 returns 1 only when B is the exact mirror of A. Code 14 returns 64 only when both operands are all ones. The signed high product needs operands at the most negative value or at minus one. Random operands almost never produce any of these. The stimulus therefore builds these cases directly: mirrored pairs from a few seed patterns, all-ones and 0x80000000 operands, a zero divisor, and shift amounts of 0 and 31 with the upper bits of B set. Random vectors for every code follow these directed cases.

// File: rtl/alu_pkg.sv
// Package: shared operation encoding for the sixteen-operation ALU.
// Assumes a 4-bit select; every one of the 16 codes is assigned.
package alu_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_AND   = 4'd0,
        OP_OR    = 4'd1,
        OP_XOR   = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_MULLO = 4'd5,
        OP_MULHU = 4'd6,
        OP_MULHS = 4'd7,
        OP_DIVU  = 4'd8,
        OP_REMU  = 4'd9,
        OP_SHR   = 4'd10,
        OP_SHRA  = 4'd11,
        OP_SHL   = 4'd12,
        OP_SLT   = 4'd13,
        OP_ONES  = 4'd14,
        OP_MIRR  = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu_simple_unit.sv
// Module: single-level operations of the ALU. Computes the bitwise logic
// results, the wrapping sum and difference, the signed less-than bit, the
// combined ones count of both operands and the mirror-equality bit.
// Assumes W >= 2. All outputs are combinational.
module alu_simple_unit #(
    parameter int W  = 32,
    parameter int CW = $clog2(2*W+1)
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  and_o,
    output logic [W-1:0]  or_o,
    output logic [W-1:0]  xor_o,
    output logic [W-1:0]  sum_o,
    output logic [W-1:0]  diff_o,
    output logic          lt_o,
    output logic [CW-1:0] ones_o,
    output logic          mirr_o
);

    logic [W-1:0] b_mirror;

    // Bitwise logic and modular add/subtract.
    assign and_o  = a_i & b_i;
    assign or_o   = a_i | b_i;
    assign xor_o  = a_i ^ b_i;
    assign sum_o  = a_i + b_i;
    assign diff_o = a_i - b_i;

    // Signed two's-complement comparison.
    assign lt_o = $signed(a_i) < $signed(b_i);

    // Mirror B bit by bit.
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign b_mirror[i] = b_i[W-1-i];
    end

    assign mirr_o = (a_i == b_mirror);

    // Sum the set bits of both operands.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CW'(a_i[i]) + CW'(b_i[i]);
        end
    end

endmodule

// File: rtl/alu_mul_unit.sv
// Module: multiplier of the ALU. Forms one unsigned 2W-bit product and
// derives the signed high word from it by subtracting each operand when
// the other one is negative, so only one multiplier array is needed.
// Assumes W >= 2. Combinational.
module alu_mul_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_u_o,
    output logic [W-1:0] hi_s_o
);

    localparam int PW = 2 * W;

    logic [PW-1:0] prod_u;
    logic [W-1:0]  corr_a;
    logic [W-1:0]  corr_b;

    // Unsigned full-width product.
    assign prod_u = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    assign lo_o   = prod_u[W-1:0];
    assign hi_u_o = prod_u[PW-1:W];

    // Sign corrections for the signed high word.
    assign corr_a = b_i[W-1] ? a_i : '0;
    assign corr_b = a_i[W-1] ? b_i : '0;
    assign hi_s_o = hi_u_o - corr_a - corr_b;

endmodule

// File: rtl/alu_div_unit.sv
// Module: unsigned restoring divider, unrolled into W compare-subtract
// stages. With a zero divisor every stage subtracts nothing, so the
// quotient becomes all ones and the remainder becomes the dividend.
// Assumes W >= 2. Combinational; depth grows linearly with W.
module alu_div_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);

    logic [W-1:0] part [0:W];

    assign part[0] = '0;

    // One stage per quotient bit, most significant first.
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic [W:0]   shifted;
        logic [W-1:0] reduced;
        logic         take;

        assign shifted   = {part[i], num_i[W-1-i]};
        assign take      = (shifted >= {1'b0, den_i});
        assign reduced   = shifted[W-1:0] - den_i;
        assign part[i+1] = take ? reduced : shifted[W-1:0];
        assign quot_o[W-1-i] = take;
    end

    assign rem_o = part[W];

endmodule

// File: rtl/alu_shift_unit.sv
// Module: barrel shifts of the ALU. Uses only the low SW bits of the
// amount; the caller passes no other bits. Combinational.
module alu_shift_unit #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  shr_o,
    output logic [W-1:0]  shra_o,
    output logic [W-1:0]  shl_o
);

    // Zero-fill right, sign-fill right and zero-fill left shifts.
    assign shr_o  = a_i >> amt_i;
    assign shra_o = W'($signed(a_i) >>> amt_i);
    assign shl_o  = a_i << amt_i;

endmodule

// File: rtl/sixteen_op_alu.sv
// Module: top of the sixteen-operation ALU. All sub-units compute in
// parallel; the operation code drives only the output multiplexer.
// Assumes no clock or reset: the result follows the inputs combinationally.
module sixteen_op_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     result_o
);

    localparam int CW = $clog2(2*W+1);
    localparam int SW = $clog2(W);

    logic [W-1:0]  and_v, or_v, xor_v, sum_v, diff_v;
    logic          lt_v, mirr_v;
    logic [CW-1:0] ones_v;
    logic [W-1:0]  mul_lo, mul_hi_u, mul_hi_s;
    logic [W-1:0]  div_quot, div_rem;
    logic [W-1:0]  shr_v, shra_v, shl_v;

    alu_simple_unit #(.W(W), .CW(CW)) simple_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .and_o  (and_v),
        .or_o   (or_v),
        .xor_o  (xor_v),
        .sum_o  (sum_v),
        .diff_o (diff_v),
        .lt_o   (lt_v),
        .ones_o (ones_v),
        .mirr_o (mirr_v)
    );

    alu_mul_unit #(.W(W)) mul_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .lo_o   (mul_lo),
        .hi_u_o (mul_hi_u),
        .hi_s_o (mul_hi_s)
    );

    alu_div_unit #(.W(W)) div_i (
        .num_i  (a_i),
        .den_i  (b_i),
        .quot_o (div_quot),
        .rem_o  (div_rem)
    );

    alu_shift_unit #(.W(W), .SW(SW)) shift_i (
        .a_i    (a_i),
        .amt_i  (b_i[SW-1:0]),
        .shr_o  (shr_v),
        .shra_o (shra_v),
        .shl_o  (shl_v)
    );

    // Select one sub-unit result by operation code.
    always_comb begin
        case (alu_op_e'(sel_i))
            OP_AND:   result_o = and_v;
            OP_OR:    result_o = or_v;
            OP_XOR:   result_o = xor_v;
            OP_ADD:   result_o = sum_v;
            OP_SUB:   result_o = diff_v;
            OP_MULLO: result_o = mul_lo;
            OP_MULHU: result_o = mul_hi_u;
            OP_MULHS: result_o = mul_hi_s;
            OP_DIVU:  result_o = div_quot;
            OP_REMU:  result_o = div_rem;
            OP_SHR:   result_o = shr_v;
            OP_SHRA:  result_o = shra_v;
            OP_SHL:   result_o = shl_v;
            OP_SLT:   result_o = {{(W-1){1'b0}}, lt_v};
            OP_ONES:  result_o = {{(W-CW){1'b0}}, ones_v};
            OP_MIRR:  result_o = {{(W-1){1'b0}}, mirr_v};
            default:  result_o = '0;
        endcase
    end

endmodule

// File: rtl/sixteen_op_alu_chk.sv
// Module: assertion checker for the ALU, bound to the top. Checks the
// result port against algebraic relations and the divider outputs
// against each other. Immediate assertions, as the block has no clock.
module sixteen_op_alu_chk
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [W-1:0]     a_i,
    input logic [W-1:0]     b_i,
    input logic [SEL_W-1:0] sel_i,
    input logic [W-1:0]     result_o,
    input logic [W-1:0]     div_quot,
    input logic [W-1:0]     div_rem
);

    localparam int PW = 2 * W;

    logic [PW-1:0] recon;

    // Rebuild the dividend from quotient and remainder.
    assign recon = {{W{1'b0}}, div_quot} * {{W{1'b0}}, b_i} + {{W{1'b0}}, div_rem};

    // Evaluate the relations whenever inputs or outputs settle.
    always_comb begin
        if (!$isunknown({a_i, b_i, sel_i, result_o, div_quot, div_rem})) begin
            if (sel_i == OP_XOR && a_i == b_i)
                AST_XOR_SELF_ZERO: assert (result_o == '0) else $error("xor self"); // R1
            if (sel_i == OP_SUB && a_i == b_i)
                AST_SUB_SELF_ZERO: assert (result_o == '0) else $error("sub self"); // R2
            if (sel_i == OP_DIVU && b_i == '0)
                AST_DIV_ZERO_ONES: assert (result_o == '1) else $error("div zero"); // R6
            if (sel_i == OP_REMU && b_i == '0)
                AST_REM_ZERO_KEEP: assert (result_o == a_i) else $error("rem zero"); // R7
            if (b_i != '0)
                AST_DIV_RECON: assert (recon == {{W{1'b0}}, a_i} && div_rem < b_i) else $error("div recon"); // R6
            if (sel_i == OP_SLT || sel_i == OP_MIRR)
                AST_FLAG_BINARY: assert (result_o <= W'(1)) else $error("flag range"); // R10
            if (sel_i == OP_ONES)
                AST_ONES_RANGE: assert (result_o <= W'(2*W)) else $error("ones range"); // R11
        end
    end

endmodule

bind sixteen_op_alu sixteen_op_alu_chk #(.W(W)) chk_i (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_i    (sel_i),
    .result_o (result_o),
    .div_quot (div_quot),
    .div_rem  (div_rem)
);

// File: tb/sixteen_op_alu_tb_top.sv
// Bench: drives operand/code vectors one per clock, compares the result
// against a behavioural reference every clock, and reports a summary.
module sixteen_op_alu_tb_top;

    logic        clk;
    logic        rst_n;
    logic [31:0] a, b;
    logic [3:0]  sel;
    logic [31:0] res;
    int          total;
    int          bad;
    bit          done;

    sixteen_op_alu #(.W(32)) dut_i (
        .a_i      (a),
        .b_i      (b),
        .sel_i    (sel),
        .result_o (res)
    );

    // 250 MHz clock.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Behavioural reference model.
    function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y);
        longint signed   sx, sy;
        logic [63:0]     pu;
        logic [63:0]     ps;
        int              n;
        logic            same;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        pu = {32'd0, x} * {32'd0, y};
        ps = 64'(sx * sy);
        case (op)
            4'd0:  return x & y;
            4'd1:  return x | y;
            4'd2:  return x ^ y;
            4'd3:  return x + y;
            4'd4:  return x - y;
            4'd5:  return pu[31:0];
            4'd6:  return pu[63:32];
            4'd7:  return ps[63:32];
            4'd8:  return (y == 0) ? 32'hFFFF_FFFF : x / y;
            4'd9:  return (y == 0) ? x : x % y;
            4'd10: return x >> y[4:0];
            4'd11: return 32'($signed(x) >>> y[4:0]);
            4'd12: return x << y[4:0];
            4'd13: return (sx < sy) ? 32'd1 : 32'd0;
            4'd14: begin
                n = $countones(x) + $countones(y);
                return 32'(n);
            end
            default: begin
                same = 1'b1;
                for (int i = 0; i < 32; i++) if (x[i] != y[31-i]) same = 1'b0;
                return {31'd0, same};
            end
        endcase
    endfunction

    // Requirement tag belonging to each code.
    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2: return "R1";
            4'd3, 4'd4:       return "R2";
            4'd5:             return "R3";
            4'd6:             return "R4";
            4'd7:             return "R5";
            4'd8:             return "R6";
            4'd9:             return "R7";
            4'd10, 4'd11:     return "R8";
            4'd12:            return "R9";
            4'd13:            return "R10";
            4'd14:            return "R11";
            default:          return "R12";
        endcase
    endfunction

    function automatic logic [31:0] mirror(input logic [31:0] x);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = x[31-i];
        return r;
    endfunction

    // Drive one vector after the edge, compare at the falling edge.
    task automatic apply(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] exp;
        @(posedge clk);
        #1;
        sel = op; a = x; b = y;
        exp = ref_model(op, x, y);
        @(negedge clk);
        total++;
        if (res !== exp) begin
            bad++;
            $display("FAIL %s code=%0d a=%h b=%h actual=%h expected=%h", req_of(op), op, x, y, res, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Main stimulus.
    initial begin
        logic [31:0] seeds [4];
        total = 0; bad = 0; done = 1'b0;
        rst_n = 1'b0; a = '0; b = '0; sel = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero operands on code 0 give zero (R1).
        total++;
        if (res !== 32'd0) begin
            bad++;
            $display("FAIL R1 reset state actual=%h expected=%h", res, 32'd0);
        end

        // Directed corners applied to every code.
        for (int op = 0; op < 16; op++) begin
            apply(4'(op), 32'h8000_0000, 32'h8000_0000);
            apply(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
            apply(4'(op), 32'h8000_0000, 32'hFFFF_FFFF);
            apply(4'(op), 32'h1234_5678, 32'h0000_0000);
            apply(4'(op), 32'h0000_0000, 32'h0000_0000);
            apply(4'(op), 32'hDEAD_BEEF, 32'h0000_001F);
            apply(4'(op), 32'h7FFF_FFFF, 32'h0000_0001);
        end

        // R8 and R9: upper bits of B have no effect on shift amount.
        apply(4'd10, 32'h8000_0001, 32'hFFFF_FFE1);
        apply(4'd11, 32'h8000_0001, 32'hFFFF_FFFF);
        apply(4'd12, 32'h0000_0003, 32'h1234_5660);
        apply(4'd11, 32'h4000_0000, 32'h0000_001F);

        // R6 and R7: divide by one and by a larger divisor.
        apply(4'd8, 32'h0000_0005, 32'h0000_0007);
        apply(4'd9, 32'h0000_0005, 32'h0000_0007);
        apply(4'd8, 32'hFFFF_FFFF, 32'h0000_0001);

        // R10: sign matters, unsigned order would disagree.
        apply(4'd13, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(4'd13, 32'h0000_0001, 32'hFFFF_FFFF);
        apply(4'd13, 32'h0000_0005, 32'h0000_0005);

        // R12: mirrored pairs give 1, near misses give 0.
        seeds[0] = 32'h0000_000F;
        seeds[1] = 32'h1234_5678;
        seeds[2] = 32'h8000_0001;
        seeds[3] = 32'hA5C3_0F96;
        foreach (seeds[k]) begin
            apply(4'd15, seeds[k], mirror(seeds[k]));
            apply(4'd15, seeds[k], mirror(seeds[k]) ^ 32'h0001_0000);
        end

        // R11: mixed counts.
        apply(4'd14, 32'hFFFF_FFFF, 32'h0000_0000);
        apply(4'd14, 32'h0F0F_0F0F, 32'h0000_0001);

        // Random vectors for every code.
        for (int n = 0; n < 40; n++) begin
            for (int op = 0; op < 16; op++) begin
                apply(4'(op), $urandom, (op == 8 || op == 9) && n < 20 ? ($urandom & 32'h0000_FFFF) : $urandom);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule